// File: doc/BRIEF.md
# Card Bus Clock Generator with Double-Rate Modes

This block derives the clock for an external memory-card bus from a source clock. Software writes one control word holding an operating mode, an 8-bit divisor and a half-rate enable. The block turns these into a card clock, and it reports a clock-stable flag in the same word. There are four modes. Single-rate divided mode and single-rate bypass mode serve ordinary transfers. Double-rate divided mode uses a fixed divide-by-four ahead of the divisor. The high-speed double-rate mode can skip the divisor and run at half the source rate.

A change to the configuration does not take effect at once. It is held until the divided clock is in a low phase and is then loaded, so the output never shows a runt pulse. The stable flag drops at the write and rises again once the new setting has run for a fixed settling time. Software polls this flag before it uses the bus again.

Top module: `card_clk_gen`

## Requirements
- R1: While reset is low, card_clk is 0. After reset the control word reads 0x0000_0080 (divisor 0, mode 0, half-rate off, stable set), and the card clock runs in mode 0 with divisor 0.
- R2: Control word layout: divisor at bits 15:8, mode at bits 17:16, half-rate enable at bit 18, stable flag at bit 7. The flag is read-only and ignores writes. Every other bit reads 0. The written fields read back on the cycle after the write.
- R3: Mode 1 passes the source clock through unchanged (period of 1 source cycle). The divisor is ignored.
- R4: In mode 0, divisor 0 gives a period of 2 source cycles, and divisor N gives 4*N cycles.
- R5: In mode 2, and in mode 3 with the half-rate enable clear, divisor 0 gives a period of 4 source cycles, and divisor N gives 8*N cycles.
- R6: In mode 3 with the half-rate enable set, the period is 2 source cycles whatever the divisor. In modes 0 to 2 the half-rate enable has no effect.
- R7: A write that changes the mode, the divisor or the half-rate enable clears the stable flag on the next cycle.
- R8: The stable flag stays clear for at least 8 source cycles after such a write. It is set again only after the new setting has run for 8 cycles, and from then on the card clock has the new period.
- R9: A write that leaves the mode, the divisor and the half-rate enable unchanged does not clear a set stable flag.
- R10: Neither a high nor a low pulse of card_clk is ever shorter than half a source period, including across any change of mode or divisor.
- R11: Once the flag is set, the card clock has a 50 % duty cycle: the high time is half the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Source clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | REG_W | Control word write data |
| cfg_rdata | output | REG_W | Control word read data, including the stable flag |
| card_clk | output | 1 | Generated card bus clock |
| clk_stable | output | 1 | Set when the card clock runs with the current setting |

## Verification
The hardest case to reach is a change that arrives mid-phase. The new setting must wait for a low phase of the old one, or must move the output into or out of source bypass, and neither may leave a runt pulse behind. The stimulus chains directed and seeded random settings back to back, so that every pair of modes follows one another, including long divisors followed by bypass and the reverse. A bench monitor times every edge of card_clk against the minimum pulse width throughout the run. Periods and duty cycle are measured in time only after the flag rises, which also confirms that the flag does not rise before the new setting is in effect.

// File: rtl/ccg_pkg.sv
// Shared types and helpers for the card clock generator.
// Assumes the three configuration fields are contiguous in the control word,
// ordered {half-rate, mode, divisor} from MSB to LSB.
package ccg_pkg;

    localparam int DIV_W   = 8;            // divisor field width
    localparam int HALF_W  = DIV_W + 2;    // holds 4*max divisor
    localparam int STB_BIT = 7;            // stable flag position
    localparam int CFG_LSB = 8;            // first bit of the field group

    typedef enum logic [1:0] {
        MODE_SDR_DIV = 2'd0,
        MODE_SDR_BYP = 2'd1,
        MODE_DDR_DIV = 2'd2,
        MODE_HS_DDR  = 2'd3
    } ccg_mode_e;

    typedef struct packed {
        logic              half_rate;
        ccg_mode_e         mode;
        logic [DIV_W-1:0]  div;
    } ccg_cfg_t;

    localparam int CFG_W = $bits(ccg_cfg_t);
    localparam int CFG_MSB = CFG_LSB + CFG_W - 1;

    // Half period of the divided clock in source cycles.
    function automatic logic [HALF_W-1:0] half_period(input ccg_cfg_t c);
        logic [HALF_W-1:0] n;
        n = HALF_W'(c.div);
        case (c.mode)
            MODE_SDR_DIV: half_period = (c.div == '0) ? HALF_W'(1) : (n << 1);
            MODE_HS_DDR:  half_period = c.half_rate ? HALF_W'(1)
                                      : ((c.div == '0) ? HALF_W'(2) : (n << 2));
            MODE_DDR_DIV: half_period = (c.div == '0) ? HALF_W'(2) : (n << 2);
            default:      half_period = HALF_W'(1);
        endcase
    endfunction

endpackage

// File: rtl/ccg_cfg_reg.sv
// Requested-configuration register.
// Holds the last written setting. Flags a changing write and keeps a pending
// bit until the divider reports that it has loaded the setting.
// Assumes apply is asserted only while pending is set.
module ccg_cfg_reg
    import ccg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      we,
    input  ccg_cfg_t  wcfg,
    input  logic      apply,
    output ccg_cfg_t  req_cfg,
    output logic      pending,
    output logic      change
);

    // Flag a write whose fields differ from the held request.
    assign change = we && (wcfg != req_cfg);

    // Hold the request and the pending bit; a new change wins over apply.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_cfg <= '0;
            pending <= 1'b0;
        end else if (change) begin
            req_cfg <= wcfg;
            pending <= 1'b1;
        end else if (apply) begin
            pending <= 1'b0;
        end
    end

endmodule

// File: rtl/ccg_divider.sv
// Divided clock and bypass selector.
// Loads a pending setting only while its output is low, which restarts the
// low phase and avoids runt pulses. The bypass select changes on the falling
// source edge, when both mux inputs are low.
module ccg_divider
    import ccg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pending,
    input  ccg_cfg_t  req_cfg,
    output logic      apply,
    output logic      card_clk
);

    ccg_cfg_t          act_cfg;
    logic [HALF_W-1:0] cnt;
    logic [HALF_W-1:0] half;
    logic              div_q;
    logic              byp_n;
    logic              act_byp;

    assign half    = half_period(act_cfg);
    assign act_byp = (act_cfg.mode == MODE_SDR_BYP);
    assign apply   = pending && !div_q;

    // Count half periods and toggle the divided clock; load new settings at a low phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_cfg <= '0;
            cnt     <= '0;
            div_q   <= 1'b0;
        end else if (apply) begin
            act_cfg <= req_cfg;
            cnt     <= '0;
            div_q   <= 1'b0;
        end else if (act_byp) begin
            cnt     <= '0;
            div_q   <= 1'b0;
        end else if (cnt == half - HALF_W'(1)) begin
            cnt     <= '0;
            div_q   <= ~div_q;
        end else begin
            cnt     <= cnt + HALF_W'(1);
        end
    end

    // Retime the bypass select into the source low phase.
    always_ff @(negedge clk) begin
        if (!rst_n) byp_n <= 1'b0;
        else        byp_n <= act_byp;
    end

    assign card_clk = byp_n ? clk : div_q;

endmodule

// File: rtl/ccg_settle.sv
// Clock-stable flag.
// Clears on a changing write. Once the divider has loaded the new setting,
// it counts SETTLE source cycles and then sets the flag again.
module ccg_settle #(
    parameter int SETTLE = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic change,
    input  logic apply,
    output logic stable
);

    localparam int CW = $clog2(SETTLE + 1);

    logic [CW-1:0] cnt;
    logic          run;

    // Drop on change, start timing on apply, rise when the count completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stable <= 1'b1;
            run    <= 1'b0;
            cnt    <= '0;
        end else if (change) begin
            stable <= 1'b0;
            run    <= 1'b0;
            cnt    <= '0;
        end else if (apply) begin
            run    <= 1'b1;
            cnt    <= '0;
        end else if (run) begin
            if (cnt == CW'(SETTLE - 1)) begin
                stable <= 1'b1;
                run    <= 1'b0;
            end else begin
                cnt    <= cnt + CW'(1);
            end
        end
    end

endmodule

// File: rtl/card_clk_gen.sv
// Card bus clock generator top.
// Decodes the control word, sequences glitch-free changes of setting and
// reports the stable flag in the read data. Assumes clk_src is free-running.
module card_clk_gen
    import ccg_pkg::*;
#(
    parameter int REG_W  = 32,
    parameter int SETTLE = 8
) (
    input  logic             clk_src,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    output logic             card_clk,
    output logic             clk_stable
);

    ccg_cfg_t wcfg;
    ccg_cfg_t req_cfg;
    logic     pending;
    logic     change;
    logic     apply;

    assign wcfg = ccg_cfg_t'(cfg_wdata[CFG_MSB:CFG_LSB]);

    ccg_cfg_reg u_reg (
        .clk     (clk_src),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .wcfg    (wcfg),
        .apply   (apply),
        .req_cfg (req_cfg),
        .pending (pending),
        .change  (change)
    );

    ccg_divider u_div (
        .clk      (clk_src),
        .rst_n    (rst_n),
        .pending  (pending),
        .req_cfg  (req_cfg),
        .apply    (apply),
        .card_clk (card_clk)
    );

    ccg_settle #(.SETTLE(SETTLE)) u_settle (
        .clk    (clk_src),
        .rst_n  (rst_n),
        .change (change),
        .apply  (apply),
        .stable (clk_stable)
    );

    // Assemble the read view: requested fields plus the stable flag.
    always_comb begin
        cfg_rdata                  = '0;
        cfg_rdata[CFG_MSB:CFG_LSB] = req_cfg;
        cfg_rdata[STB_BIT]         = clk_stable;
    end

endmodule

// File: rtl/ccg_checker.sv
// Port-level properties of the card clock generator, bound to the top.
module ccg_checker
    import ccg_pkg::*;
#(
    parameter int REG_W  = 32,
    parameter int SETTLE = 8
) (
    input logic             clk_src,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [REG_W-1:0] cfg_wdata,
    input logic [REG_W-1:0] cfg_rdata,
    input logic             clk_stable
);

    logic       chg;
    logic [4:0] since_chg;

    assign chg = cfg_we && (cfg_wdata[CFG_MSB:CFG_LSB] != cfg_rdata[CFG_MSB:CFG_LSB]);

    // Cycles since the last changing write, saturating.
    always_ff @(posedge clk_src) begin
        if (!rst_n)              since_chg <= 5'd31;
        else if (chg)            since_chg <= 5'd0;
        else if (since_chg != 5'd31) since_chg <= since_chg + 5'd1;
    end

    AST_RSVD_ZERO: assert property (@(posedge clk_src) disable iff (!rst_n)
        cfg_rdata[STB_BIT-1:0] == '0 && cfg_rdata[REG_W-1:CFG_MSB+1] == '0); // R2

    AST_FIELDS_LOADED: assert property (@(posedge clk_src) disable iff (!rst_n)
        cfg_we |=> cfg_rdata[CFG_MSB:CFG_LSB] == $past(cfg_wdata[CFG_MSB:CFG_LSB])); // R2

    AST_FIELDS_HOLD: assert property (@(posedge clk_src) disable iff (!rst_n)
        !cfg_we |=> $stable(cfg_rdata[CFG_MSB:CFG_LSB])); // R2

    AST_STABLE_DROP: assert property (@(posedge clk_src) disable iff (!rst_n)
        chg |=> !clk_stable); // R7

    AST_SETTLE_MIN: assert property (@(posedge clk_src) disable iff (!rst_n)
        $rose(clk_stable) |-> since_chg >= 5'(SETTLE)); // R8

    AST_SAME_KEEPS: assert property (@(posedge clk_src) disable iff (!rst_n)
        (cfg_we && !chg && clk_stable) |=> clk_stable); // R9

    AST_FLAG_MIRROR: assert property (@(posedge clk_src) disable iff (!rst_n)
        cfg_rdata[STB_BIT] == clk_stable); // R2

endmodule

bind card_clk_gen ccg_checker #(.REG_W(REG_W), .SETTLE(SETTLE)) u_chk (
    .clk_src    (clk_src),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .clk_stable (clk_stable)
);

// File: tb/sim_card_clk_gen.sv
`timescale 1ns/1ps
module sim_card_clk_gen;

    localparam real TCK = 5.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        card_clk;
    logic        clk_stable;

    int checks = 0;
    int errors = 0;
    int glitches = 0;
    bit done = 1'b0;
    logic [10:0] cur_req = '0;
    realtime last_edge = 0;

    always #(TCK/2) clk = ~clk;

    card_clk_gen u0 (
        .clk_src    (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .card_clk   (card_clk),
        .clk_stable (clk_stable)
    );

    // R10 monitor: every card clock pulse must last at least half a source period.
    always @(card_clk) begin
        if (rst_n && last_edge > 0 && ($realtime - last_edge) < (TCK/2 - 0.1))
            glitches++;
        last_edge = $realtime;
    end

    function automatic int exp_period(input logic [1:0] m, input logic [7:0] d, input bit hr);
        if (m == 2'd1)          return 1;
        if (m == 2'd0)          return (d == 0) ? 2 : 4 * int'(d);
        if (m == 2'd3 && hr)    return 2;
        return (d == 0) ? 4 : 8 * int'(d);
    endfunction

    function automatic string req_of(input logic [1:0] m, input bit hr);
        if (m == 2'd1) return "R3";
        if (m == 2'd0) return hr ? "R6" : "R4";
        if (m == 2'd3 && hr) return "R6";
        return hr ? "R6" : "R5";
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input real act, input real exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0.3f expected %0.3f", req, what, act, exp);
        end
    endtask

    task automatic measure(input logic [1:0] m, input logic [7:0] d, input bit hr);
        realtime t0, t1, t2;
        real p;
        p = exp_period(m, d, hr) * TCK;
        @(posedge card_clk); t0 = $realtime;
        @(negedge card_clk); t1 = $realtime;
        @(posedge card_clk); t2 = $realtime;
        check((t2 - t0) > p - 0.01 && (t2 - t0) < p + 0.01, req_of(m, hr), "period",
              t2 - t0, p);
        check((t1 - t0) > p/2 - 0.01 && (t1 - t0) < p/2 + 0.01, "R11", "high time",
              t1 - t0, p/2);
    endtask

    task automatic set_cfg(input logic [1:0] m, input logic [7:0] d, input bit hr);
        logic [31:0] w;
        bit changed;
        int n;
        w = $urandom;
        w[18:8] = {hr, m, d};
        changed = (w[18:8] != cur_req);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
        cur_req = {hr, m, d};
        check(cfg_rdata == {13'd0, hr, m, d, clk_stable, 7'd0}, "R2", "readback",
              real'(cfg_rdata), real'({13'd0, hr, m, d, clk_stable, 7'd0}));
        if (changed) begin
            check(clk_stable == 1'b0, "R7", "stable after change", real'(clk_stable), 0.0);
            n = 0;
            while (!clk_stable && n < 6000) begin
                n++;
                @(negedge clk);
            end
            check(n >= 8, "R8", "settle cycles", real'(n), 8.0);
            check(clk_stable == 1'b1, "R8", "stable rises", real'(clk_stable), 1.0);
        end else begin
            n = 0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (!clk_stable) n++;
            end
            check(n == 0, "R9", "unchanged write kept stable", real'(n), 0.0);
        end
        measure(m, d, hr);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        check(card_clk == 1'b0, "R1", "clock low in reset", real'(card_clk), 0.0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(cfg_rdata == 32'h80, "R1", "reset word", real'(cfg_rdata), 128.0);
        measure(2'd0, 8'd0, 1'b0);

        // Directed corners
        set_cfg(2'd0, 8'd1, 1'b0);
        set_cfg(2'd0, 8'd2, 1'b0);
        set_cfg(2'd0, 8'd255, 1'b0);
        set_cfg(2'd1, 8'd0, 1'b0);
        set_cfg(2'd1, 8'd77, 1'b1);
        set_cfg(2'd2, 8'd255, 1'b0);
        set_cfg(2'd1, 8'd77, 1'b1);
        set_cfg(2'd2, 8'd0, 1'b0);
        set_cfg(2'd2, 8'd1, 1'b0);
        set_cfg(2'd2, 8'd2, 1'b0);
        set_cfg(2'd2, 8'd3, 1'b1);
        set_cfg(2'd3, 8'd0, 1'b0);
        set_cfg(2'd3, 8'd1, 1'b0);
        set_cfg(2'd3, 8'd255, 1'b0);
        set_cfg(2'd3, 8'd0, 1'b1);
        set_cfg(2'd3, 8'd200, 1'b1);
        set_cfg(2'd3, 8'd200, 1'b1);   // identical write, R9
        set_cfg(2'd0, 8'd0, 1'b1);
        set_cfg(2'd0, 8'd0, 1'b1);     // identical write, R9

        // Seeded random settings
        for (int k = 0; k < 12; k++)
            set_cfg(2'($urandom % 4), 8'($urandom % 6), 1'($urandom % 2));

        check(glitches == 0, "R10", "short pulses", real'(glitches), 0.0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule